// File: doc/BRIEF.md
# Multi-Channel Wiper Register Stepper

This block keeps the wiper-position codes of three digital resistor channels and changes them in response to adjustment commands. Channel A is 7 bits wide (128 positions). Channels B and C are 9 bits wide (512 positions). A command can move a channel linearly by one code or logarithmically by about 6 dB. The logarithmic step shifts the code left to double it or right to halve it. A command is sent to one selected channel or broadcast to all three.

Two load paths bypass the stepping logic. A direct-write port puts any code into one channel. A restore port loads all three channels at once with values saved earlier; it is meant for use at power-up. The outputs are the three current codes, and each output is a register.

A two-state controller decides when step commands are accepted. After reset it is in `ST_BOOT`, where step commands are ignored and only direct writes and restores take effect. The transition `BOOT_TO_RUN` fires on the first restore strobe. In `ST_RUN` step commands take effect. A restore in `ST_RUN` takes the transition `RUN_HOLD` and reloads the codes without leaving `ST_RUN`. Nothing returns the controller to `ST_BOOT` except reset.

Top module: `wiper_stepper`

## Requirements
- R1: While `rst_n` is low, all three wiper outputs are 0 and the controller is in `ST_BOOT`.
- R2: In `ST_BOOT`, step commands have no effect. The first `restore_valid` moves the controller to `ST_RUN`, and step commands apply from the next cycle on.
- R3: When `restore_valid` is high, every channel loads its field of `restore_codes` on the next clock edge. The fields are: A in bits [6:0], B in bits [15:7], C in bits [24:16].
- R4: When `wr_valid` is high, the channel chosen by `wr_sel` loads the low bits of `wr_code` that fit its width. The select values are 0 = A, 1 = B, 2 = C. The value 3 selects no channel.
- R5: Opcode 0 adds one to the code. At full scale (127 for A, 511 for B and C) the code stays at full scale.
- R6: Opcode 1 subtracts one from the code. At 0 the code stays at 0.
- R7: Opcode 2 shifts the code left by one bit. A code of 0 becomes 1. A code at or above midscale (64 for A, 256 for B and C) becomes full scale.
- R8: Opcode 3 shifts the code right by one bit and drops the LSB. A code of 0 stays at 0.
- R9: When `cmd_all` is 1, a step command updates all three channels on the same clock edge. When `cmd_all` is 0, `cmd_sel` selects the channel (0 = A, 1 = B, 2 = C), and the value 3 updates no channel.
- R10: A restore overrides a direct write in the same cycle. If either a restore or a direct write is present in a cycle, the step command in that cycle is dropped for every channel.
- R11: Opcodes 4 to 7 leave all codes unchanged.
- R12: In a cycle with no `cmd_valid`, no `wr_valid` and no `restore_valid`, all codes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle strobe that marks a step command |
| cmd_op | input | 3 | Step opcode: 0 inc, 1 dec, 2 shift left, 3 shift right |
| cmd_all | input | 1 | Send the step command to all channels |
| cmd_sel | input | 2 | Target channel when `cmd_all` is 0 |
| wr_valid | input | 1 | Direct-write strobe |
| wr_sel | input | 2 | Channel to write |
| wr_code | input | WMAX (9) | Code to write, low bits used |
| restore_valid | input | 1 | Restore strobe that loads all channels |
| restore_codes | input | WTOT (25) | Packed restore codes, channel A in the low bits |
| wiper_a | output | W_A (7) | Current code of channel A |
| wiper_b | output | W_B (9) | Current code of channel B |
| wiper_c | output | W_C (9) | Current code of channel C |

## Verification
Every result arrives exactly one clock edge after its strobe. This holds for loads, restores and steps, and for the `BOOT_TO_RUN` transition. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It reads the outputs at that same falling edge, which is half a cycle after the edge that registered the stimulus. The sweep first writes every code of every channel and then applies each of the four opcodes to it. The expected codes are worked out arithmetically from the channel width.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
    localparam logic [2:0] OP_INC = 3'd0;
    localparam logic [2:0] OP_DEC = 3'd1;
    localparam logic [2:0] OP_SHL = 3'd2;
    localparam logic [2:0] OP_SHR = 3'd3;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } phase_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/wstep_fsm.sv
module wstep_fsm
    import wstep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restore_valid,
    output logic run
);
    phase_e state_q;
    phase_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: BOOT_TO_RUN on restore, RUN_HOLD otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (restore_valid) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    // outputs
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_BOOT: run = 1'b0;
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end
endmodule

// File: rtl/wstep_chan.sv
module wstep_chan
    import wstep_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_fire,
    input  logic [W-1:0] ld_code,
    input  logic         step_fire,
    input  logic [2:0]   step_op,
    output logic [W-1:0] code_q
);
    localparam logic [W-1:0] FULL = {W{1'b1}};
    localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] stepped;

    always_comb begin
        stepped = code_q;
        unique case (step_op)
            OP_INC: if (code_q != FULL) stepped = code_q + ONE;
            OP_DEC: if (code_q != '0) stepped = code_q - ONE;
            OP_SHL: begin
                if (code_q == '0)       stepped = ONE;
                else if (code_q >= MID) stepped = FULL;
                else                    stepped = code_q << 1;
            end
            OP_SHR: stepped = code_q >> 1;
            default: stepped = code_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (ld_fire) begin
            code_q <= ld_code;
        end else if (step_fire) begin
            code_q <= stepped;
        end
    end
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
    import wstep_pkg::*;
#(
    parameter int W_A  = 7,
    parameter int W_B  = 9,
    parameter int W_C  = 9,
    parameter int WMAX = max3(W_A, W_B, W_C),
    parameter int WTOT = W_A + W_B + W_C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic            cmd_all,
    input  logic [1:0]      cmd_sel,
    input  logic            wr_valid,
    input  logic [1:0]      wr_sel,
    input  logic [WMAX-1:0] wr_code,
    input  logic            restore_valid,
    input  logic [WTOT-1:0] restore_codes,
    output logic [W_A-1:0]  wiper_a,
    output logic [W_B-1:0]  wiper_b,
    output logic [W_C-1:0]  wiper_c
);
    localparam int NCH = 3;

    logic run;
    logic step_ok;

    wstep_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .restore_valid (restore_valid),
        .run           (run)
    );

    // loads win over steps for the whole cycle
    assign step_ok = cmd_valid & run & ~wr_valid & ~restore_valid & (cmd_op <= OP_SHR);

    for (genvar g = 0; g < NCH; g++) begin : gen_ch
        localparam int CW  = (g == 0) ? W_A : ((g == 1) ? W_B : W_C);
        localparam int OFF = (g == 0) ? 0 : ((g == 1) ? W_A : W_A + W_B);

        logic [CW-1:0] code_q;
        logic [CW-1:0] ld_code;
        logic          ld_fire;
        logic          hit;

        assign ld_fire = restore_valid | (wr_valid & (wr_sel == 2'(g)));
        assign ld_code = restore_valid ? restore_codes[OFF +: CW] : wr_code[CW-1:0];
        assign hit     = step_ok & (cmd_all | (cmd_sel == 2'(g)));

        wstep_chan #(.W(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_fire   (ld_fire),
            .ld_code   (ld_code),
            .step_fire (hit),
            .step_op   (cmd_op),
            .code_q    (code_q)
        );
    end

    assign wiper_a = gen_ch[0].code_q;
    assign wiper_b = gen_ch[1].code_q;
    assign wiper_c = gen_ch[2].code_q;
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
    parameter int W_A  = 7,
    parameter int W_B  = 9,
    parameter int W_C  = 9,
    parameter int WMAX = 9,
    parameter int WTOT = 25
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [2:0]      cmd_op,
    input logic            cmd_all,
    input logic [1:0]      cmd_sel,
    input logic            wr_valid,
    input logic [1:0]      wr_sel,
    input logic [WMAX-1:0] wr_code,
    input logic            restore_valid,
    input logic [WTOT-1:0] restore_codes,
    input logic [W_A-1:0]  wiper_a,
    input logic [W_B-1:0]  wiper_b,
    input logic [W_C-1:0]  wiper_c,
    input logic            run
);
    logic a_step;
    logic quiet;
    assign a_step = cmd_valid & ~wr_valid & ~restore_valid & (cmd_all | (cmd_sel == 2'd0));
    assign quiet  = ~cmd_valid & ~wr_valid & ~restore_valid;

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> ($stable(wiper_a) && $stable(wiper_b) && $stable(wiper_c)));

    // R3
    restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |=> (wiper_a == $past(restore_codes[W_A-1:0])
                        && wiper_b == $past(restore_codes[W_A +: W_B])
                        && wiper_c == $past(restore_codes[W_A+W_B +: W_C])));

    // R4
    write_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !restore_valid && wr_sel == 2'd0) |=> (wiper_a == $past(wr_code[W_A-1:0])));

    // R5
    inc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_step && cmd_op == 3'd0 && wiper_a == {W_A{1'b1}}) |=> (wiper_a == {W_A{1'b1}}));

    // R6
    dec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_step && cmd_op == 3'd1 && wiper_a == '0) |=> (wiper_a == '0));

    // R7
    shl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_step && run && cmd_op == 3'd2 && wiper_a == '0) |=> (wiper_a == W_A'(1)));

    // R8
    shr_nogrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_step && cmd_op == 3'd3) |=> (wiper_a <= $past(wiper_a)));

    // R2
    boot_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_valid && !restore_valid) |=> $stable(wiper_b));
endmodule

bind wiper_stepper wiper_stepper_chk #(
    .W_A(W_A), .W_B(W_B), .W_C(W_C), .WMAX(WMAX), .WTOT(WTOT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_all(cmd_all), .cmd_sel(cmd_sel), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .wr_code(wr_code), .restore_valid(restore_valid), .restore_codes(restore_codes),
    .wiper_a(wiper_a), .wiper_b(wiper_b), .wiper_c(wiper_c), .run(run)
);

// File: tb/wiper_stepper_tb_top.sv
module wiper_stepper_tb_top;
    localparam int W_A = 7;
    localparam int W_B = 9;
    localparam int W_C = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic        cmd_all = 1'b0;
    logic [1:0]  cmd_sel = '0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [8:0]  wr_code = '0;
    logic        restore_valid = 1'b0;
    logic [24:0] restore_codes = '0;
    logic [6:0]  wiper_a;
    logic [8:0]  wiper_b;
    logic [8:0]  wiper_c;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wiper_stepper #(.W_A(W_A), .W_B(W_B), .W_C(W_C)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_all(cmd_all), .cmd_sel(cmd_sel), .wr_valid(wr_valid), .wr_sel(wr_sel),
        .wr_code(wr_code), .restore_valid(restore_valid), .restore_codes(restore_codes),
        .wiper_a(wiper_a), .wiper_b(wiper_b), .wiper_c(wiper_c)
    );

    function automatic int chan_w(input int ch);
        return (ch == 0) ? W_A : ((ch == 1) ? W_B : W_C);
    endfunction

    function automatic int get_w(input int ch);
        return (ch == 0) ? int'(wiper_a) : ((ch == 1) ? int'(wiper_b) : int'(wiper_c));
    endfunction

    function automatic int exp_step(input int op, input int v, input int w);
        int full;
        int mid;
        full = (1 << w) - 1;
        mid  = 1 << (w - 1);
        case (op)
            0: return (v == full) ? full : v + 1;
            1: return (v == 0) ? 0 : v - 1;
            2: return (v == 0) ? 1 : ((v >= mid) ? full : v * 2);
            3: return v / 2;
            default: return v;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        cmd_valid = 1'b0; wr_valid = 1'b0; restore_valid = 1'b0;
        cmd_all = 1'b0; cmd_sel = '0; cmd_op = '0; wr_sel = '0; wr_code = '0;
    endtask

    // drive at a falling edge, release at the next one; outputs are then settled
    task automatic do_write(input int sel, input int code);
        @(negedge clk);
        wr_valid = 1'b1; wr_sel = 2'(sel); wr_code = 9'(code);
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_cmd(input int op, input bit all, input int sel);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_all = all; cmd_sel = 2'(sel);
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_restore(input int a, input int b, input int c);
        @(negedge clk);
        restore_valid = 1'b1;
        restore_codes = {9'(c), 9'(b), 7'(a)};
        @(negedge clk);
        clear_in();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        string rq;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 a", get_w(0), 0);
        chk("R1 b", get_w(1), 0);
        chk("R1 c", get_w(2), 0);
        rst_n = 1'b1;

        // R2 steps ignored in boot, write accepted
        do_cmd(0, 1'b1, 0);
        chk("R2 boot inc a", get_w(0), 0);
        chk("R2 boot inc c", get_w(2), 0);
        do_write(1, 40);
        do_cmd(2, 1'b0, 1);
        chk("R2 boot shl ignored", get_w(1), 40);

        // R3 restore
        do_restore(5, 300, 17);
        chk("R3 a", get_w(0), 5);
        chk("R3 b", get_w(1), 300);
        chk("R3 c", get_w(2), 17);
        // R2 run after restore
        do_cmd(0, 1'b0, 0);
        chk("R2 run inc a", get_w(0), 6);

        // R4 write truncation and sel 3
        do_write(0, 511);
        chk("R4 trunc a", get_w(0), 127);
        do_write(3, 99);
        chk("R4 sel3 a", get_w(0), 127);
        chk("R4 sel3 b", get_w(1), 300);
        chk("R4 sel3 c", get_w(2), 17);

        // R5..R8 exhaustive per channel, per opcode
        for (int ch = 0; ch < 3; ch++) begin
            for (int op = 0; op < 4; op++) begin
                for (int v = 0; v < (1 << chan_w(ch)); v++) begin
                    do_write(ch, v);
                    do_cmd(op, 1'b0, ch);
                    rq = (op == 0) ? "R5" : (op == 1) ? "R6" : (op == 2) ? "R7" : "R8";
                    chk(rq, get_w(ch), exp_step(op, v, chan_w(ch)));
                end
            end
        end

        // R9 broadcast
        do_write(0, 127); do_write(1, 0); do_write(2, 200);
        do_cmd(2, 1'b1, 3);
        chk("R9 all a", get_w(0), 127);
        chk("R9 all b", get_w(1), 1);
        chk("R9 all c", get_w(2), 400);
        do_cmd(3, 1'b1, 0);
        chk("R9 all shr a", get_w(0), 63);
        chk("R9 all shr b", get_w(1), 0);
        chk("R9 all shr c", get_w(2), 200);
        do_cmd(0, 1'b0, 3);
        chk("R9 sel3 a", get_w(0), 63);
        chk("R9 sel3 c", get_w(2), 200);

        // R10 priority
        @(negedge clk);
        wr_valid = 1'b1; wr_sel = 2'd1; wr_code = 9'd77;
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_all = 1'b1;
        @(negedge clk);
        clear_in();
        chk("R10 write b", get_w(1), 77);
        chk("R10 step dropped a", get_w(0), 63);
        chk("R10 step dropped c", get_w(2), 200);
        @(negedge clk);
        restore_valid = 1'b1; restore_codes = {9'd9, 9'd8, 7'd7};
        wr_valid = 1'b1; wr_sel = 2'd0; wr_code = 9'd100;
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_all = 1'b1;
        @(negedge clk);
        clear_in();
        chk("R10 restore wins a", get_w(0), 7);
        chk("R10 restore b", get_w(1), 8);
        chk("R10 restore c", get_w(2), 9);

        // R11 unused opcodes
        for (int op = 4; op < 8; op++) begin
            do_cmd(op, 1'b1, 0);
            chk("R11 a", get_w(0), 7);
            chk("R11 b", get_w(1), 8);
            chk("R11 c", get_w(2), 9);
        end

        // R12 idle hold
        repeat (4) @(negedge clk);
        chk("R12 a", get_w(0), 7);
        chk("R12 b", get_w(1), 8);
        chk("R12 c", get_w(2), 9);

        done = 1'b1;
        finish_run();
    end
endmodule